// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. A frame is a start bit, a character of 8, 9 or 10 bit times, and one or two stop bits. When parity is on, the last bit of the character is a parity bit over the data bits below it, so the character length counts the parity bit. The character can leave least significant bit first or most significant bit first, and the line can be inverted. Bit boundaries come from a one-cycle baud tick that an outside divider produces.

A one-entry holding buffer takes a word through a load strobe. The word moves into the shift register at the first usable tick, which frees the buffer for the next word. Frames can therefore follow each other with no idle gap. A send-break request produces a run of zeros. Its length depends on the character length and the stop-bit count, and a long-break select adds three bit times. While the request stays high, breaks follow one another.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, buf_empty and tx_complete are 1 and the line rests at its idle level. The idle level is 1 when tx_invert is 0, and 0 when tx_invert is 1.
- R2: A frame starts at a baud tick when tx_enable is 1, a word is waiting and no frame or break is running. Before inversion the frame is a 0 start bit, the character bits, then stop bits of 1. Each bit lasts exactly one tick interval. The character length is 8 bits for char_len 0, 9 bits for char_len 1, and 10 bits for char_len 2 or 3.
- R3: With parity_en at 1, the last character bit is a parity bit over the lower (length-1) bits of the word. With parity_odd at 0 it makes the count of ones even, and with parity_odd at 1 it makes the count odd. With parity_en at 0, every character bit is data.
- R4: two_stop at 0 sends one stop bit and two_stop at 1 sends two. tx_complete rises at the tick that ends the last stop bit.
- R5: With msb_first at 0, word bit 0 follows the start bit. With msb_first at 1, the highest data bit goes first and word bit 0 goes last among the data bits. The parity bit, when present, always comes right before the stop bits.
- R6: With tx_invert at 1, tx_out is the bit-wise inverse of the line described in R2, R9 and R11.
- R7: buf_empty falls in the cycle after a load strobe. It rises in the cycle after the tick that moves the word into the shift register. If a load falls in that same cycle, the new word is kept, buf_empty stays 0, and the new word is sent next with no gap.
- R8: tx_complete is 0 while a frame or a break is being sent, or while a word is waiting. Otherwise it is 1.
- R9: A break is a run of 0 (before inversion). It starts at a tick when send_break is 1, no word is waiting and the transmitter is free. Its length is character length + 1 + stop count bit times (10 to 13). With long_break at 1 the length is 3 bit times more (13 to 16).
- R10: While send_break stays 1, a new break starts at the tick that ends the previous one, so the line stays low with no gap.
- R11: With tx_enable at 0, no frame starts, the line stays idle and a loaded word is held.
- R12: Changes to char_len, parity or bit order during a frame do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Allows frames and breaks to start |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| load | input | 1 | Writes load_data into the holding buffer |
| load_data | input | 10 | Character to send |
| char_len | input | 2 | 0: 8 bits, 1: 9 bits, 2 or 3: 10 bits |
| parity_en | input | 1 | Last character bit is a parity bit |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| msb_first | input | 1 | Sends the highest data bit first |
| tx_invert | input | 1 | Inverts the serial output |
| send_break | input | 1 | Requests break characters |
| long_break | input | 1 | Adds three bit times to each break |
| tx_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer can take a word |
| tx_complete | output | 1 | Nothing sent or waiting |

## Verification
The case most likely to go wrong is a load strobe that arrives on the same edge as the tick that moves the waiting word into the shift register. The bench holds a word while tx_enable is low. It then raises the enable and strobes a second word so that both land on the same tick edge. It judges the result by checking that buf_empty stays low, and that both frames are captured back to back with their exact bit patterns. A second coincidence is a break that is still requested at the tick that ends the previous break. Here the low run must measure exactly twice the break length.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int CHAR_MAX = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_enable,
  input  logic                baud_tick,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] load_data,
  input  logic [1:0]          char_len,
  input  logic                parity_en,
  input  logic                parity_odd,
  input  logic                two_stop,
  input  logic                msb_first,
  input  logic                tx_invert,
  input  logic                send_break,
  input  logic                long_break,
  output logic                tx_out,
  output logic                buf_empty,
  output logic                tx_complete
);

  localparam int FRAME_W = CHAR_MAX + 3;
  localparam int IW      = $clog2(CHAR_MAX + 1);
  localparam int CNT_W   = $clog2(CHAR_MAX + 7);

  logic                full, busy, brk;
  logic [CHAR_MAX-1:0] hold;
  logic [FRAME_W-1:0]  shreg, fr;
  logic [CNT_W-1:0]    cnt, flen, blen;
  logic [IW-1:0]       nchar, nd;
  logic                par;
  logic                slot, take_word, take_brk;

  always_comb begin
    case (char_len)
      2'd0:    nchar = IW'(8);
      2'd1:    nchar = IW'(9);
      default: nchar = IW'(10);
    endcase
    nd  = nchar - IW'(parity_en);
    par = parity_odd;
    fr  = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (IW'(i) < nd) begin
        par = par ^ hold[i];
        fr[i+1] = msb_first ? hold[IW'(nd - IW'(1) - IW'(i))] : hold[i];
      end
    end
    for (int i = 0; i < CHAR_MAX; i++)
      if (parity_en && IW'(i) == nd) fr[i+1] = par;
    flen = CNT_W'(nchar) + CNT_W'(two_stop ? 3 : 2);
    blen = flen + CNT_W'(long_break ? 3 : 0);
  end

  assign slot      = baud_tick && tx_enable && (!busy || cnt == CNT_W'(1));
  assign take_word = slot && full;
  assign take_brk  = slot && !full && send_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      brk   <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
    end else if (take_word) begin
      busy  <= 1'b1;
      brk   <= 1'b0;
      shreg <= fr;
      cnt   <= flen;
    end else if (take_brk) begin
      busy  <= 1'b1;
      brk   <= 1'b1;
      shreg <= '0;
      cnt   <= blen;
    end else if (baud_tick && busy) begin
      shreg <= {!brk, shreg[FRAME_W-1:1]};
      if (cnt == CNT_W'(1)) busy <= 1'b0;
      else                  cnt  <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (load) begin
      full <= 1'b1;
      hold <= load_data;
    end else if (take_word) begin
      full <= 1'b0;
    end
  end

  assign tx_out      = (busy ? shreg[0] : 1'b1) ^ tx_invert;
  assign buf_empty   = !full;
  assign tx_complete = !busy && !full;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |-> tx_out == !tx_invert); // R1
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(shreg) && $stable(busy)); // R2
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !buf_empty); // R7
  AST_EMPTY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick) && $past(tx_enable)); // R7
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && brk |-> tx_out == tx_invert); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0 && cnt <= CNT_W'(CHAR_MAX + 6)); // R9
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable && !busy |=> !busy); // R11

endmodule

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
  logic clk = 0, rst_n = 0;
  logic tx_enable = 0, baud_tick = 0, load = 0;
  logic [9:0] load_data = '0;
  logic [1:0] char_len = 0;
  logic parity_en = 0, parity_odd = 0, two_stop = 0, msb_first = 0;
  logic tx_invert = 0, send_break = 0, long_break = 0;
  logic tx_out, buf_empty, tx_complete;
  int checks = 0, errors = 0;
  bit done = 0;

  uart_frame_tx i_uart_frame_tx (.*);

  always #2.5 clk = ~clk;

  initial begin
    int tcnt = 0;
    forever begin
      @(posedge clk); #1;
      tcnt++;
      baud_tick = (tcnt % 8 == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input bit pe, input bit od, input bit two,
                         input bit msb, input bit inv);
    @(negedge clk);
    char_len = l; parity_en = pe; parity_odd = od; two_stop = two;
    msb_first = msb; tx_invert = inv;
  endtask

  task automatic expect_frame(input logic [9:0] d, output logic [15:0] bits, output int t);
    int n, nd;
    bit p;
    n  = (char_len == 0) ? 8 : (char_len == 1) ? 9 : 10;
    nd = n - int'(parity_en);
    p  = parity_odd;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      p ^= d[i];
      bits[4'(1 + i)] = msb_first ? d[4'(nd - 1 - i)] : d[i];
    end
    if (parity_en) bits[4'(1 + nd)] = p;
    t = 1 + n + (two_stop ? 2 : 1);
  endtask

  task automatic capture(input int t, input bit sync, input bit scramble,
                         output logic [15:0] got, output bit tc_last);
    int guard = 0;
    got = '1;
    tc_last = 1'b1;
    if (sync) @(negedge clk);
    while (tx_out != tx_invert && guard < 2000) begin
      @(negedge clk); guard++;
    end
    for (int j = 0; j < 8 * t; j++) begin
      if (j % 8 == 3) got[4'(j / 8)] = tx_out ^ tx_invert;
      if (j == 8 * t - 1) tc_last = tx_complete;
      if (scramble && j == 10) begin
        char_len = 2'd2; parity_en = 1; msb_first = ~msb_first; two_stop = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic load_word(input logic [9:0] d);
    @(negedge clk);
    load = 1; load_data = d;
    @(negedge clk);
    load = 0;
  endtask

  task automatic send_check(input logic [9:0] d, input string tag);
    logic [15:0] exp_b, got;
    int t;
    bit tcl;
    expect_frame(d, exp_b, t);
    load_word(d);
    chk(!buf_empty, {tag, " R7 buffer full after load"}, int'(buf_empty), 0);
    capture(t, 1, 0, got, tcl);
    chk(got == exp_b, {tag, " frame bits"}, int'(got), int'(exp_b));
    chk(tcl == 0, {tag, " R4 R8 busy during last bit"}, int'(tcl), 0);
    chk(tx_complete == 1, {tag, " R4 R8 complete at frame end"}, int'(tx_complete), 1);
  endtask

  task automatic t_reset;
    chk(tx_out == 1, "R1 idle line", int'(tx_out), 1);
    chk(buf_empty == 1, "R1 buf_empty", int'(buf_empty), 1);
    chk(tx_complete == 1, "R1 tx_complete", int'(tx_complete), 1);
  endtask

  task automatic t_frames;
    set_cfg(0, 0, 0, 0, 0, 0); send_check(10'h0A5, "R2 8N1 lsb");
    set_cfg(1, 1, 0, 1, 0, 0); send_check(10'h0B3, "R3 R4 9bit even two-stop");
    set_cfg(2, 1, 1, 0, 1, 0); send_check(10'h2C5, "R5 R3 10bit odd msb");
    set_cfg(0, 0, 0, 0, 1, 0); send_check(10'h03C, "R5 8bit msb");
    set_cfg(3, 0, 0, 1, 0, 0); send_check(10'h3A7, "R2 R4 10bit lsb");
    set_cfg(0, 1, 1, 0, 0, 1);
    @(negedge clk);
    chk(tx_out == 0, "R6 inverted idle level", int'(tx_out), 0);
    send_check(10'h071, "R6 inverted odd parity");
  endtask

  task automatic t_hold_and_coincide;
    logic [15:0] ea, eb, got;
    int ta, tb;
    bit tcl, bad = 0;
    set_cfg(0, 0, 0, 0, 0, 0);
    tx_enable = 0;
    load_word(10'h0C3);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx_out != 1 || buf_empty || tx_complete) bad = 1;
    end
    chk(!bad, "R11 disabled holds word, line idle", int'(bad), 0);
    expect_frame(10'h0C3, ea, ta);
    expect_frame(10'h05A, eb, tb);
    do begin @(posedge clk); #2; end while (!baud_tick);
    tx_enable = 1; load = 1; load_data = 10'h05A;
    @(posedge clk); #2;
    load = 0;
    @(negedge clk);
    chk(!buf_empty, "R7 load on transfer tick keeps buffer full", int'(buf_empty), 0);
    capture(ta, 0, 0, got, tcl);
    chk(got == ea, "R7 first frame", int'(got), int'(ea));
    chk(tx_out == 0, "R7 second frame starts with no gap", int'(tx_out), 0);
    capture(tb, 0, 0, got, tcl);
    chk(got == eb, "R7 second frame", int'(got), int'(eb));
    chk(tx_complete == 1, "R8 complete after both frames", int'(tx_complete), 1);
  endtask

  task automatic t_break(input logic [1:0] l, input bit two, input bit lng, input int len,
                         input int reps, input string tag);
    int j = 0;
    bit tc_bad = 0;
    set_cfg(l, 0, 0, two, 0, 0);
    long_break = lng;
    send_break = 1;
    @(negedge clk);
    while (tx_out != 0 && j < 2000) begin @(negedge clk); j++; end
    j = 0;
    while (tx_out == 0 && j < 2000) begin
      if (tx_complete) tc_bad = 1;
      if (j == 8 * len * (reps - 1) + 3) send_break = 0;
      @(negedge clk); j++;
    end
    chk(j == 8 * len * reps, {tag, " break low run in cycles"}, j, 8 * len * reps);
    chk(!tc_bad, "R8 tx_complete low during break", int'(tc_bad), 0);
    chk(tx_complete == 1, {tag, " complete after break"}, int'(tx_complete), 1);
    long_break = 0;
  endtask

  task automatic t_midframe;
    logic [15:0] e, got;
    int t;
    bit tcl;
    set_cfg(0, 0, 0, 0, 0, 0);
    expect_frame(10'h1E6, e, t);
    load_word(10'h1E6);
    capture(t, 1, 1, got, tcl);
    chk(got == e, "R12 config change mid-frame ignored", int'(got), int'(e));
    chk(tcl == 0 && tx_complete == 1, "R12 frame length unchanged", int'(tx_complete), 1);
  endtask

  initial begin
    #(750_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    tx_enable = 1;
    t_frames();
    t_hold_and_coincide();
    t_break(0, 0, 0, 10, 1, "R9 8bit one-stop normal");
    t_break(2, 1, 1, 16, 1, "R9 10bit two-stop long");
    t_break(1, 0, 1, 14, 1, "R9 9bit one-stop long");
    t_break(0, 1, 0, 11, 2, "R10 held break back to back");
    t_midframe();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule